// File: doc/BRIEF.md
# Windowed Register File Controller

This block is the integer register file of a 32-bit core whose registers are arranged in overlapping windows. Every 5-bit architectural register number is resolved against a current window pointer. The first eight numbers always select a bank of globals that every window shares. The other three groups of eight are the outs, the locals and the ins of the current window. Each window owns its locals. Its ins are the same storage as the outs of the next higher window, so a caller's outs become the callee's ins after a save without moving any data.

The controller keeps the window pointer and a per-window invalid mask. Save requests decrement the pointer and restore requests increment it, both modulo the window count. A request is refused, with an overflow or underflow flag raised in the same cycle, when the window it would move to is marked invalid. Trap entry always steps the pointer down by one and ignores the mask. A privileged control write loads the pointer and the mask directly. Two combinational read ports and one clocked write port serve the datapath. A read of the register being written in the same cycle sees the new value.

Top module: `regwin_file`

## Requirements
- R1: Register numbers 0 to 7 select globals, which read the same from every window. 8 to 15 select the outs, 16 to 23 the locals and 24 to 31 the ins of the current window.
- R2: Register 0 always reads as zero, including in the cycle it is written, and writes to it are dropped.
- R3: An accepted save sets the window pointer to (pointer − 1) mod NWIN on the next clock edge, so 0 wraps to NWIN−1.
- R4: An accepted restore sets the window pointer to (pointer + 1) mod NWIN on the next clock edge, so NWIN−1 wraps to 0.
- R5: A save whose target window has its mask bit set to 1 (invalid) drives overflow high in that cycle and leaves the pointer unchanged. Bit k of the mask belongs to window k, and 0 means valid.
- R6: A restore whose target window has its mask bit set to 1 drives underflow high in that cycle and leaves the pointer unchanged.
- R7: The outs (8 to 15) of window N are the same storage as the ins (24 to 31) of window (N−1) mod NWIN.
- R8: Trap entry sets the pointer to (pointer − 1) mod NWIN whatever the mask holds, and it never raises overflow.
- R9: A read port that addresses the physical register being written in the same cycle returns the write data.
- R10: After reset the pointer and the mask are 0. A control write loads both on the next edge and takes priority over trap entry, save and restore.
- R11: The locals of each window are private, so a write to a local in one window leaves that local in other windows unchanged.
- R12: When save and restore are requested together and trap entry is not, only the save is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move to the next higher window |
| trap_enter | input | 1 | Open a trap window without checking the mask |
| ctl_we | input | 1 | Privileged load of pointer and mask |
| ctl_cwp | input | WBITS | Pointer value for the control write |
| ctl_wim | input | NWIN | Mask value for the control write |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register number |
| wr_data | input | XLEN | Write data |
| cwp | output | WBITS | Current window pointer |
| wim | output | NWIN | Window invalid mask |
| overflow | output | 1 | Save refused this cycle |
| underflow | output | 1 | Restore refused this cycle |

## Verification
The hardest case to reach from the ports is the in/out overlap. A value written as an out can only be seen as an in after the pointer has moved down, and going back must return to the original locals. The stimulus table therefore writes outs and locals, saves, reads the ins and writes fresh locals, then restores twice and checks that every window kept its own data. Refused moves need a mask bit placed next to the pointer, so directed steps first use the control write to place the pointer beside an invalid window and then request the move in the direction that is refused.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     save_req,
  input  logic                     restore_req,
  input  logic                     trap_enter,
  input  logic                     ctl_we,
  input  logic [$clog2(NWIN)-1:0]  ctl_cwp,
  input  logic [NWIN-1:0]          ctl_wim,
  input  logic [4:0]               rd_a_addr,
  output logic [XLEN-1:0]          rd_a_data,
  input  logic [4:0]               rd_b_addr,
  output logic [XLEN-1:0]          rd_b_data,
  input  logic                     wr_en,
  input  logic [4:0]               wr_addr,
  input  logic [XLEN-1:0]          wr_data,
  output logic [$clog2(NWIN)-1:0]  cwp,
  output logic [NWIN-1:0]          wim,
  output logic                     overflow,
  output logic                     underflow
);
  localparam int WBITS = $clog2(NWIN);
  localparam int NPHYS = 8 + 16 * NWIN;
  localparam int PBITS = $clog2(NPHYS);

  logic [XLEN-1:0]  rf [NPHYS];
  logic [WBITS-1:0] cwp_dec, cwp_inc;
  logic [PBITS-1:0] pa, pb, pw;
  logic             save_ok, restore_ok;

  function automatic logic [PBITS-1:0] phys(input logic [4:0] a, input logic [WBITS-1:0] w);
    logic [WBITS-1:0] wn;
    wn = w + 1'b1;
    case (a[4:3])
      2'd0:    phys = PBITS'(a[2:0]);
      2'd1:    phys = PBITS'(16 + 16 * int'(w) + int'(a[2:0]));
      2'd2:    phys = PBITS'(8 + 16 * int'(w) + int'(a[2:0]));
      default: phys = PBITS'(16 + 16 * int'(wn) + int'(a[2:0]));
    endcase
  endfunction

  assign cwp_dec = cwp - 1'b1;
  assign cwp_inc = cwp + 1'b1;
  assign pa = phys(rd_a_addr, cwp);
  assign pb = phys(rd_b_addr, cwp);
  assign pw = phys(wr_addr, cwp);

  assign save_ok    = !ctl_we && !trap_enter && save_req;
  assign restore_ok = !ctl_we && !trap_enter && !save_req && restore_req;
  assign overflow   = save_ok && wim[cwp_dec];
  assign underflow  = restore_ok && wim[cwp_inc];

  assign rd_a_data = (pa == '0) ? '0 : (wr_en && pw == pa) ? wr_data : rf[pa];
  assign rd_b_data = (pb == '0) ? '0 : (wr_en && pw == pb) ? wr_data : rf[pb];

  always_ff @(posedge clk)
    if (wr_en && pw != '0) rf[pw] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cwp <= '0;
      wim <= '0;
    end else if (ctl_we) begin
      cwp <= ctl_cwp;
      wim <= ctl_wim;
    end else if (trap_enter) begin
      cwp <= cwp_dec;
    end else if (save_ok && !wim[cwp_dec]) begin
      cwp <= cwp_dec;
    end else if (restore_ok && !wim[cwp_inc]) begin
      cwp <= cwp_inc;
    end

  assert_g0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_addr == 5'd0 |-> rd_a_data == '0);

  assert_save_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !ctl_we && !trap_enter && !overflow) |=> cwp == WBITS'($past(cwp) - 1'b1));

  assert_restore_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !ctl_we && !trap_enter && !underflow)
      |=> cwp == WBITS'($past(cwp) + 1'b1));

  assert_no_move_on_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> $stable(cwp));

  assert_no_move_on_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> $stable(cwp));

  assert_trap_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter && !ctl_we) |=> cwp == WBITS'($past(cwp) - 1'b1));

  assert_trap_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |-> !overflow && !underflow);

  assert_ctl_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> cwp == $past(ctl_cwp) && wim == $past(ctl_wim));

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));
endmodule

// File: tb/regwin_file_bench.sv
module regwin_file_bench;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic save_req = 0, restore_req = 0, trap_enter = 0, ctl_we = 0, wr_en = 0;
  logic [2:0] ctl_cwp = '0;
  logic [NWIN-1:0] ctl_wim = '0;
  logic [4:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic [XLEN-1:0] rd_a_data, rd_b_data;
  logic [2:0] cwp;
  logic [NWIN-1:0] wim;
  logic overflow, underflow;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  regwin_file #(.NWIN(NWIN), .XLEN(XLEN)) u_regwin_file (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .trap_enter(trap_enter), .ctl_we(ctl_we), .ctl_cwp(ctl_cwp), .ctl_wim(ctl_wim),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data), .rd_b_addr(rd_b_addr),
    .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cwp(cwp), .wim(wim), .overflow(overflow), .underflow(underflow));

  // op[38:37]: 0 write, 1 read-check on port A, 2 save, 3 restore; addr[36:32]; data[31:0]
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 5'd1,  32'h11}, {2'd0, 5'd8,  32'hA0}, {2'd0, 5'd16, 32'hB0},
    {2'd2, 5'd0,  32'h0},  {2'd1, 5'd24, 32'hA0}, {2'd1, 5'd1,  32'h11},
    {2'd0, 5'd16, 32'hC7}, {2'd3, 5'd0,  32'h0},  {2'd1, 5'd16, 32'hB0},
    {2'd1, 5'd8,  32'hA0}, {2'd0, 5'd0,  32'hFFFF}, {2'd1, 5'd0, 32'h0},
    {2'd2, 5'd0,  32'h0},  {2'd1, 5'd16, 32'hC7}, {2'd0, 5'd8,  32'h77},
    {2'd2, 5'd0,  32'h0},  {2'd1, 5'd24, 32'h77}, {2'd3, 5'd0,  32'h0},
    {2'd3, 5'd0,  32'h0},  {2'd1, 5'd8,  32'hA0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    save_req = 0; restore_req = 0; trap_enter = 0; ctl_we = 0; wr_en = 0;
  endtask

  task automatic ctl_load(input logic [2:0] p, input logic [NWIN-1:0] m);
    ctl_we = 1; ctl_cwp = p; ctl_wim = m;
    step();
    idle();
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk("R10 reset cwp", 32'(cwp), 32'd0);
    chk("R10 reset wim", 32'(wim), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][38:37])
        2'd0: begin wr_en = 1; wr_addr = VEC[i][36:32]; wr_data = VEC[i][31:0]; step(); idle(); end
        2'd1: begin
          rd_a_addr = VEC[i][36:32];
          #1 chk($sformatf("R1 R2 R7 R11 table step %0d", i), rd_a_data, VEC[i][31:0]);
        end
        2'd2: begin save_req = 1; step(); idle(); end
        default: begin restore_req = 1; step(); idle(); end
      endcase
    end
    chk("R4 table end pointer", 32'(cwp), 32'd0);

    save_req = 1; step(); idle();
    chk("R3 save wraps 0 to 7", 32'(cwp), 32'd7);
    restore_req = 1; step(); idle();
    chk("R4 restore wraps 7 to 0", 32'(cwp), 32'd0);

    ctl_we = 1; ctl_cwp = 3'd3; ctl_wim = 8'h04; save_req = 1; step(); idle();
    chk("R10 load beats save cwp", 32'(cwp), 32'd3);
    chk("R10 load wim", 32'(wim), 32'h04);

    save_req = 1;
    #1 chk("R5 overflow flag", 32'(overflow), 32'd1);
    step(); idle();
    chk("R5 pointer held", 32'(cwp), 32'd3);

    ctl_load(3'd1, 8'h04);
    restore_req = 1;
    #1 chk("R6 underflow flag", 32'(underflow), 32'd1);
    step(); idle();
    chk("R6 pointer held", 32'(cwp), 32'd1);

    ctl_load(3'd7, 8'h40);
    trap_enter = 1;
    #1 chk("R8 trap no overflow", 32'(overflow), 32'd0);
    step(); idle();
    chk("R8 trap into invalid window", 32'(cwp), 32'd6);

    ctl_load(3'd4, 8'h00);
    save_req = 1; restore_req = 1;
    #1 chk("R12 no underflow", 32'(underflow), 32'd0);
    step(); idle();
    chk("R12 save wins", 32'(cwp), 32'd3);

    wr_en = 1; wr_addr = 5'd24; wr_data = 32'h55; rd_b_addr = 5'd24;
    #1 chk("R9 same-cycle bypass", rd_b_data, 32'h55);
    step(); idle();
    restore_req = 1; step(); idle();
    rd_a_addr = 5'd8;
    #1 chk("R7 in of window 3 is out of window 4", rd_a_data, 32'h55);
    rd_a_addr = 5'd1;
    #1 chk("R1 global seen from window 4", rd_a_data, 32'h11);

    wr_en = 1; wr_addr = 5'd0; wr_data = 32'hDEAD; rd_b_addr = 5'd0;
    #1 chk("R2 zero during write", rd_b_data, 32'h0);
    step(); idle();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1..timeout actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule